// File: doc/BRIEF.md
# Dual Fixed-Constant Pipelined Multiplier

This block takes an unsigned operand and multiplies it by two constants fixed at design time, 3171 and 2426. Both products come out at the same time on separate ports. Each product is built from shifted copies of the operand that are added or subtracted. There is no general multiplier array. The factor 3171 is split as 3 × 1057, so a triple of the operand is formed once and then reused. The factor 2426 uses a signed-digit form, 2048 + 256 + 128 − 8 + 2, which needs five terms where the plain binary form needs seven.

The adder network is split across three register stages, so a new operand can be taken on every clock. A valid flag travels alongside the data. Each register stage loads only when the valid bit that enters it is set. This makes the outputs hold their last product while no result is due. A synchronous active-high reset clears the data registers and the valid stages.

Top module: `cmul_dual_const`

## Requirements
- R1: While reset is high and in the cycle after it is released, out_valid is 0 and both products read 0.
- R2: When out_valid is 1, prod_a equals the operand accepted with it multiplied by 3171, as an exact 24-bit unsigned value.
- R3: When out_valid is 1, prod_b equals the operand accepted with it multiplied by 2426, as an exact 24-bit unsigned value.
- R4: An operand presented with in_valid = 1 in clock cycle n produces out_valid = 1 in cycle n+3. A cycle with in_valid = 0 produces out_valid = 0 three cycles later.
- R5: Operands presented on consecutive cycles each produce their own result on consecutive cycles, so the period is one clock.
- R6: While out_valid is 0, prod_a and prod_b keep their previous values. An operand presented with in_valid = 0 has no effect on them.
- R7: The operand values 0 and 4095 give 0 and 12985245 on prod_a, and 0 and 9934470 on prod_b, with no carry lost.
- R8: A reset asserted while results are in flight discards them. No out_valid pulse appears for operands accepted before that reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the cycle whose operand is to be multiplied |
| operand | input | IN_W (12) | Unsigned multiplicand |
| out_valid | output | 1 | High for one cycle per result, three cycles after acceptance |
| prod_a | output | 2*IN_W (24) | Operand times 3171 |
| prod_b | output | 2*IN_W (24) | Operand times 2426 |

## Verification
The bench builds the block with its default operand width of 12 bits. At that width the whole input space, 4096 values, can be driven back to back in one sweep. Every product, including both extremes, is therefore compared against an arithmetic product computed in the bench. A second phase sends several hundred pseudo-random operands with gaps between them and changes the operand during the idle cycles, which shows that the outputs hold. A reset in the middle of a stream shows that results still in flight are dropped.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

  // pipeline depth from accepted operand to registered products
  localparam int unsigned CM_LAT = 3;

  // the two hard-wired factors
  localparam int unsigned K_A = 3171;
  localparam int unsigned K_B = 2426;

  // K_A = 3 * (1 + 2^5 + 2^10)
  localparam int unsigned KA_TRI_SH = 1;
  localparam int unsigned KA_MID_SH = 5;
  localparam int unsigned KA_TOP_SH = 10;

  // K_B = 2^11 + 2^8 + 2^7 - 2^3 + 2^1 (signed-digit form)
  localparam int unsigned KB_SH_P0 = 11;
  localparam int unsigned KB_SH_P1 = 8;
  localparam int unsigned KB_SH_P2 = 7;
  localparam int unsigned KB_SH_N0 = 3;
  localparam int unsigned KB_SH_P3 = 1;

endpackage

// File: rtl/cmul_valid_pipe.sv
module cmul_valid_pipe #(
  parameter int unsigned DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_v,
  output logic [DEPTH-1:0] stg_v
);

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_stage
      if (gi == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) stg_v[gi] <= 1'b0;
          else     stg_v[gi] <= in_v;
        end
      end else begin : g_tail
        always_ff @(posedge clk) begin
          if (rst) stg_v[gi] <= 1'b0;
          else     stg_v[gi] <= stg_v[gi-1];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/cmul_k3171_path.sv
module cmul_k3171_path
  import cmul_pkg::*;
#(
  parameter int unsigned IN_W  = 12,
  parameter int unsigned OUT_W = 2 * IN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CM_LAT-1:0] en,
  input  logic [IN_W-1:0]   x,
  output logic [OUT_W-1:0]  prod
);

  logic [OUT_W-1:0] xw;
  logic [OUT_W-1:0] tri_q;   // stage 1: 3x
  logic [OUT_W-1:0] low_q;   // stage 2: 3x + 3x*32
  logic [OUT_W-1:0] high_q;  // stage 2: 3x*1024

  assign xw = OUT_W'(x);

  always_ff @(posedge clk) begin
    if (rst)        tri_q <= '0;
    else if (en[0]) tri_q <= (xw << KA_TRI_SH) + xw;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      low_q  <= '0;
      high_q <= '0;
    end else if (en[1]) begin
      low_q  <= tri_q + (tri_q << KA_MID_SH);
      high_q <= tri_q << KA_TOP_SH;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        prod <= '0;
    else if (en[2]) prod <= low_q + high_q;
  end

endmodule

// File: rtl/cmul_k2426_path.sv
module cmul_k2426_path
  import cmul_pkg::*;
#(
  parameter int unsigned IN_W  = 12,
  parameter int unsigned OUT_W = 2 * IN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CM_LAT-1:0] en,
  input  logic [IN_W-1:0]   x,
  output logic [OUT_W-1:0]  prod
);

  logic [OUT_W-1:0] xw;
  logic [OUT_W-1:0] hi_q;    // stage 1: 2^11 x + 2^8 x
  logic [OUT_W-1:0] mid_q;   // stage 1: 2^7 x - 2^3 x
  logic [OUT_W-1:0] lo_q;    // stage 1: 2 x
  logic [OUT_W-1:0] sum_q;   // stage 2
  logic [OUT_W-1:0] lo2_q;   // stage 2

  assign xw = OUT_W'(x);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q  <= '0;
      mid_q <= '0;
      lo_q  <= '0;
    end else if (en[0]) begin
      hi_q  <= (xw << KB_SH_P0) + (xw << KB_SH_P1);
      mid_q <= (xw << KB_SH_P2) - (xw << KB_SH_N0);
      lo_q  <= xw << KB_SH_P3;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= '0;
      lo2_q <= '0;
    end else if (en[1]) begin
      sum_q <= hi_q + mid_q;
      lo2_q <= lo_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        prod <= '0;
    else if (en[2]) prod <= sum_q + lo2_q;
  end

endmodule

// File: rtl/cmul_dual_const.sv
module cmul_dual_const
  import cmul_pkg::*;
#(
  parameter int unsigned IN_W = 12,
  localparam int unsigned OUT_W = 2 * IN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  operand,
  output logic             out_valid,
  output logic [OUT_W-1:0] prod_a,
  output logic [OUT_W-1:0] prod_b
);

  localparam logic [OUT_W-1:0] KA_W = OUT_W'(K_A);
  localparam logic [OUT_W-1:0] KB_W = OUT_W'(K_B);

  logic [CM_LAT-1:0] stg_v;
  logic [CM_LAT-1:0] ld_en;

  cmul_valid_pipe #(.DEPTH(CM_LAT)) u_vpipe (
    .clk   (clk),
    .rst   (rst),
    .in_v  (in_valid),
    .stg_v (stg_v)
  );

  // stage k loads when the valid bit entering it is set
  assign ld_en     = {stg_v[CM_LAT-2:0], in_valid};
  assign out_valid = stg_v[CM_LAT-1];

  cmul_k3171_path #(.IN_W(IN_W), .OUT_W(OUT_W)) u_path_a (
    .clk  (clk),
    .rst  (rst),
    .en   (ld_en),
    .x    (operand),
    .prod (prod_a)
  );

  cmul_k2426_path #(.IN_W(IN_W), .OUT_W(OUT_W)) u_path_b (
    .clk  (clk),
    .rst  (rst),
    .en   (ld_en),
    .x    (operand),
    .prod (prod_b)
  );

  // R4: accepted operand surfaces exactly three cycles later
  a_r4_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##3 out_valid);

  // R4, R8: no result without a matching accepted operand
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##3 !out_valid);

  // R2
  a_r2_prod_a: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (prod_a == OUT_W'($past(operand, 3)) * KA_W));

  // R3
  a_r3_prod_b: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (prod_b == OUT_W'($past(operand, 3)) * KB_W));

  // R6
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst)) |-> ($stable(prod_a) && $stable(prod_b)));

endmodule

// File: tb/cmul_dual_const_tb_top.sv
module cmul_dual_const_tb_top;

  localparam int IN_W  = 12;
  localparam int OUT_W = 2 * IN_W;
  localparam int HMAX  = 16384;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [IN_W-1:0]  operand = '0;
  logic             out_valid;
  logic [OUT_W-1:0] prod_a;
  logic [OUT_W-1:0] prod_b;

  always #5 clk = ~clk;

  cmul_dual_const #(.IN_W(IN_W)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .operand   (operand),
    .out_valid (out_valid),
    .prod_a    (prod_a),
    .prod_b    (prod_b)
  );

  int checks = 0;
  int fails  = 0;
  int k      = 0;
  bit done   = 1'b0;
  bit hv [HMAX];
  int hx [HMAX];
  logic [OUT_W-1:0] epa = '0;
  logic [OUT_W-1:0] epb = '0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string tag, input logic [OUT_W-1:0] act,
                     input logic [OUT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (step %0d)", tag, act, exp, k);
    end
  endtask

  // one clock: drive inputs, let the edge pass, compare outputs
  task automatic step(input bit v, input int x, input bit r, input string vtag);
    bit    ev;
    int    ex;
    string ta, tb;
    rst      = r;
    in_valid = v;
    operand  = IN_W'(x);
    hv[k] = v && !r;
    hx[k] = x;
    if (r) begin
      if (k >= 1) hv[k-1] = 1'b0;
      if (k >= 2) hv[k-2] = 1'b0;
    end
    @(posedge clk);
    #1;
    ev = (k >= 2) ? hv[k-2] : 1'b0;
    ex = (k >= 2) ? hx[k-2] : 0;
    if (r) begin
      epa = '0;
      epb = '0;
    end else if (ev) begin
      epa = OUT_W'(ex * 3171);
      epb = OUT_W'(ex * 2426);
    end
    if (r)                     begin ta = vtag; tb = vtag; end
    else if (!ev)              begin ta = "R6"; tb = "R6"; end
    else if (ex == 0 || ex == 4095) begin ta = "R7"; tb = "R7"; end
    else                       begin ta = "R2"; tb = "R3"; end
    chk(r ? vtag : vtag, OUT_W'(out_valid), OUT_W'(ev));
    chk(ta, prod_a, epa);
    chk(tb, prod_b, epb);
    k++;
  endtask

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) step(1'b1, 4095, 1'b1, "R1");
    step(1'b0, 0, 1'b0, "R1");

    // R5: exhaustive back-to-back sweep (R2, R3, R7 checked on the way)
    for (int x = 0; x < 4096; x++) step(1'b1, x, 1'b0, "R5");
    for (int i = 0; i < 4; i++) step(1'b0, 77, 1'b0, "R4");

    // R6: sparse random operands, operand wiggles while idle
    for (int n = 0; n < 320; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(1'b1, int'(lfsr[11:0]), 1'b0, "R4");
      step(1'b0, int'(~lfsr[11:0]), 1'b0, "R4");
      step(1'b0, int'(lfsr[15:4]), 1'b0, "R4");
    end
    for (int i = 0; i < 4; i++) step(1'b0, 4095, 1'b0, "R4");

    // R7: extremes isolated
    step(1'b1, 4095, 1'b0, "R4");
    step(1'b0, 1, 1'b0, "R4");
    step(1'b0, 2, 1'b0, "R4");
    step(1'b1, 0, 1'b0, "R4");
    for (int i = 0; i < 4; i++) step(1'b0, 3, 1'b0, "R4");

    // R8: reset with results in flight
    step(1'b1, 1000, 1'b0, "R4");
    step(1'b1, 2000, 1'b0, "R4");
    step(1'b1, 3000, 1'b0, "R8");
    step(1'b0, 0, 1'b1, "R8");
    for (int i = 0; i < 4; i++) step(1'b0, 555, 1'b0, "R8");
    step(1'b1, 1234, 1'b0, "R4");
    for (int i = 0; i < 4; i++) step(1'b0, 9, 1'b0, "R4");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule